// File: doc/BRIEF.md
# AEGIS-128 State Update Core

This block keeps the 640-bit AEGIS-128 state as five 128-bit words and advances it by one step for each 128-bit message word it accepts. A step runs one unkeyed AES round on every state word at once. The round uses SubBytes, ShiftRows and MixColumns, and its round key is all zeros. Each round result is XORed into the following word of a ring. Word 0 receives the round of the old last word, XORed together with the incoming message word. Every term of the update is taken from the state as it stood before the step.

A controller writes a complete state through the load port. It then streams message words over a valid/ready handshake, and it reads the state back from the readout port. The block accepts one word per clock. A one-cycle done pulse marks each step that was taken. Key and IV setup, tag generation and the cipher-text path belong to the logic around this block.

Top module: `aegis_step_core`

## Requirements
- R1: While `rstN` is low, `msgReady` and `stepDone` are 0 and `stateOut` reads all zeros. `msgReady` is 1 in the first cycle after reset is released.
- R2: When `loadEn` is 1 at a rising edge, `stateOut` equals `loadState` after that edge. Word k of the state occupies bits [128k+127:128k], and byte b of a word occupies bits [8b+7:8b].
- R3: After a step, word k for k in 1..4 equals old word k XOR R(old word k-1).
- R4: After a step, word 0 equals old word 0 XOR R(old word 4) XOR the message word.
- R5: R is one AES round with a zero round key. SubBytes uses the AES S-box. ShiftRows sets output byte i from input byte 4*(((i/4)+(i%4))%4)+(i%4), so the bytes are column-major. MixColumns uses the AES matrix over GF(2^8) with the polynomial 0x11B. For example, R of an all-zero word is 0x63 in every byte.
- R6: A step happens only at a rising edge where `msgValid` and `msgReady` are both 1. On any other edge without a load, `stateOut` holds its value.
- R7: `stepDone` is 1 for exactly the cycle that follows each edge at which a step was taken, and 0 at all other times.
- R8: While `loadEn` is 1, `msgReady` is 0. A message presented in that cycle is not consumed, the loaded value wins, and no `stepDone` follows.
- R9: With `msgValid` held high, one step completes on every clock with no idle cycles in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Write `loadState` into the state register |
| loadState | input | 640 | Full state image to load, word 0 in the low bits |
| msgValid | input | 1 | Message word is present |
| msgData | input | 128 | Message word, byte 0 in bits [7:0] |
| msgReady | output | 1 | The block can take a message word this cycle |
| stepDone | output | 1 | A step was taken at the previous edge |
| stateOut | output | 640 | Current contents of the state register |

## Verification
A load or a step changes `stateOut` at the same rising edge that samples it. The bench therefore drives inputs on a falling edge and waits for one rising edge. It compares the state at the next falling edge. `stepDone` is due in that same window and must be low again one cycle later, so the bench checks it at both points. `msgReady` depends combinationally on `loadEn`. The bench checks it shortly after driving the inputs, before the edge that would consume the message. The expected state comes from a separate round model in the bench. That model builds its S-box by searching for each multiplicative inverse.

// File: rtl/aegis_step_pkg.sv
package aegis_step_pkg;

  localparam int BYTE_BITS = 8;

  typedef struct packed {
    logic loadStb;
    logic stepStb;
  } ctrlStbT;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // Inverse as a^254 built from successive squares; zero maps to zero.
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gfMul(sq, sq);
      acc = gfMul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    logic [7:0] r;
    r = a;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic logic [7:0] subByte(input logic [7:0] a);
    logic [7:0] b;
    b = gfInv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_round_zk.sv
module aes_round_zk
  import aegis_step_pkg::*;
#(
  parameter int WORD_BITS = 128
) (
  input  logic [WORD_BITS-1:0] dIn,
  output logic [WORD_BITS-1:0] dOut
);

  localparam int NUM_BYTES = WORD_BITS / BYTE_BITS;
  localparam int NUM_COLS  = NUM_BYTES / 4;

  logic [NUM_BYTES-1:0][7:0] inBytes;
  logic [NUM_BYTES-1:0][7:0] subBytes;
  logic [NUM_BYTES-1:0][7:0] mixBytes;

  assign inBytes = dIn;

  // Row shift, then byte substitution per lane.
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    localparam int ROW = i % 4;
    localparam int COL = i / 4;
    localparam int SRC = 4 * ((COL + ROW) % NUM_COLS) + ROW;
    assign subBytes[i] = subByte(inBytes[SRC]);
  end

  // Column mixing; the zero round key adds nothing.
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [7:0] a0, a1, a2, a3;
    assign a0 = subBytes[4*c];
    assign a1 = subBytes[4*c+1];
    assign a2 = subBytes[4*c+2];
    assign a3 = subBytes[4*c+3];
    assign mixBytes[4*c]   = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mixBytes[4*c+1] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mixBytes[4*c+2] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mixBytes[4*c+3] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  assign dOut = mixBytes;

endmodule

// File: rtl/aegis_step_ctrl.sv
module aegis_step_ctrl
  import aegis_step_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadEn,
  input  logic    msgValid,
  output logic    msgReady,
  output logic    stepDone,
  output ctrlStbT ctrlStb
);

  logic readyQ;
  logic doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      doneQ  <= ctrlStb.stepStb;
    end
  end

  assign msgReady        = readyQ & ~loadEn;
  assign ctrlStb.loadStb = loadEn;
  assign ctrlStb.stepStb = msgValid & msgReady;
  assign stepDone        = doneQ;

  AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> stepDone); // R7
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !(msgValid && msgReady) |=> !stepDone); // R7
  AST_LOAD_BLOCKS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && msgValid) |=> !stepDone); // R8

endmodule

// File: rtl/aegis_step_dp.sv
module aegis_step_dp
  import aegis_step_pkg::*;
#(
  parameter int NUM_WORDS = 5,
  parameter int WORD_BITS = 128
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStbT                        ctrlStb,
  input  logic [NUM_WORDS*WORD_BITS-1:0] loadState,
  input  logic [WORD_BITS-1:0]           msgData,
  output logic [NUM_WORDS*WORD_BITS-1:0] stateOut
);

  logic [NUM_WORDS-1:0][WORD_BITS-1:0] stateQ;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] roundOut;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] stateNext;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    aes_round_zk #(.WORD_BITS(WORD_BITS)) u_round (
      .dIn  (stateQ[k]),
      .dOut (roundOut[k])
    );
    if (k == 0) begin : g_head
      assign stateNext[k] = stateQ[k] ^ roundOut[NUM_WORDS-1] ^ msgData;
    end else begin : g_ring
      assign stateNext[k] = stateQ[k] ^ roundOut[k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
    end else if (ctrlStb.loadStb) begin
      stateQ <= loadState;
    end else if (ctrlStb.stepStb) begin
      stateQ <= stateNext;
    end
  end

  assign stateOut = stateQ;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.loadStb |=> (stateOut == $past(loadState))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStb.loadStb && !ctrlStb.stepStb) |=> $stable(stateOut)); // R6
  AST_RING_WORD1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.stepStb && !ctrlStb.loadStb) |=>
      ((stateQ[1] ^ $past(stateQ[1])) == $past(roundOut[0]))); // R3
  AST_HEAD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.stepStb && !ctrlStb.loadStb) |=>
      ((stateQ[0] ^ $past(stateQ[0]) ^ $past(msgData)) == $past(roundOut[NUM_WORDS-1]))); // R4

endmodule

// File: rtl/aegis_step_core.sv
module aegis_step_core
  import aegis_step_pkg::*;
#(
  parameter int NUM_WORDS = 5,
  parameter int WORD_BITS = 128,
  localparam int STATE_BITS = NUM_WORDS * WORD_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadEn,
  input  logic [STATE_BITS-1:0] loadState,
  input  logic                  msgValid,
  input  logic [WORD_BITS-1:0]  msgData,
  output logic                  msgReady,
  output logic                  stepDone,
  output logic [STATE_BITS-1:0] stateOut
);

  ctrlStbT ctrlStb;

  aegis_step_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .msgValid (msgValid),
    .msgReady (msgReady),
    .stepDone (stepDone),
    .ctrlStb  (ctrlStb)
  );

  aegis_step_dp #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlStb   (ctrlStb),
    .loadState (loadState),
    .msgData   (msgData),
    .stateOut  (stateOut)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |-> (!msgReady && !stepDone)); // R1

endmodule

// File: tb/aegis_step_core_tb_top.sv
module aegis_step_core_tb_top;

  localparam int NW = 5;
  localparam int WB = 128;
  localparam int SB = NW * WB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b0;
  logic [SB-1:0] loadState = '0;
  logic          msgValid = 1'b0;
  logic [WB-1:0] msgData = '0;
  logic          msgReady;
  logic          stepDone;
  logic [SB-1:0] stateOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] sboxTab [256];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  aegis_step_core dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadState(loadState),
    .msgValid(msgValid), .msgData(msgData), .msgReady(msgReady),
    .stepDone(stepDone), .stateOut(stateOut)
  );

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [127:0] refRound(input logic [127:0] w);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = sboxTab[w[8*i +: 8]];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) t[4*c+r] = s[4*((c+r)%4)+r];
    for (int c = 0; c < 4; c++) begin
      o[8*(4*c)   +: 8] = mul(2,t[4*c]) ^ mul(3,t[4*c+1]) ^ t[4*c+2] ^ t[4*c+3];
      o[8*(4*c+1) +: 8] = t[4*c] ^ mul(2,t[4*c+1]) ^ mul(3,t[4*c+2]) ^ t[4*c+3];
      o[8*(4*c+2) +: 8] = t[4*c] ^ t[4*c+1] ^ mul(2,t[4*c+2]) ^ mul(3,t[4*c+3]);
      o[8*(4*c+3) +: 8] = mul(3,t[4*c]) ^ t[4*c+1] ^ t[4*c+2] ^ mul(2,t[4*c+3]);
    end
    return o;
  endfunction

  function automatic logic [SB-1:0] refStep(input logic [SB-1:0] st, input logic [WB-1:0] m);
    logic [SB-1:0] n;
    n[0 +: WB] = st[0 +: WB] ^ refRound(st[(NW-1)*WB +: WB]) ^ m;
    for (int k = 1; k < NW; k++)
      n[k*WB +: WB] = st[k*WB +: WB] ^ refRound(st[(k-1)*WB +: WB]);
    return n;
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic randWide(output logic [SB-1:0] v);
    for (int i = 0; i < SB/32; i++) begin
      seed = nextRand(seed);
      v[32*i +: 32] = seed;
    end
  endtask

  task automatic check(input string tag, input logic [SB-1:0] act, input logic [SB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [SB-1:0] v);
    @(negedge clk);
    loadEn = 1'b1; loadState = v;
    @(posedge clk);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 ready in reset", SB'(msgReady), '0);
    check("R1 done in reset", SB'(stepDone), '0);
    check("R1 state in reset", stateOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", SB'(msgReady), SB'(1));
  endtask

  task automatic testLoad();
    logic [SB-1:0] v;
    randWide(v);
    doLoad(v);
    check("R2 load readout", stateOut, v);
    check("R2 no done on load", SB'(stepDone), '0);
  endtask

  task automatic testZeroStep();
    logic [WB-1:0] m = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff;
    logic [WB-1:0] c63 = {16{8'h63}};
    doLoad('0);
    msgValid = 1'b1; msgData = m;
    @(posedge clk);
    @(negedge clk);
    msgValid = 1'b0;
    check("R5 zero-state step", stateOut, {c63, c63, c63, c63, c63 ^ m});
    check("R7 done after step", SB'(stepDone), SB'(1));
    @(negedge clk);
    check("R7 done is one cycle", SB'(stepDone), '0);
  endtask

  task automatic testBackToBack();
    logic [SB-1:0] exp;
    logic [SB-1:0] v;
    randWide(v);
    doLoad(v);
    exp = v;
    for (int n = 0; n < 6; n++) begin
      seed = nextRand(seed);
      msgData = {seed, ~seed, seed ^ 32'h5a5a_a5a5, 32'(n)};
      msgValid = 1'b1;
      exp = refStep(exp, msgData);
      @(posedge clk);
      @(negedge clk);
      check("R3 R4 R9 streamed step", stateOut, exp);
      check("R7 R9 done each cycle", SB'(stepDone), SB'(1));
    end
    msgValid = 1'b0;
  endtask

  task automatic testIdle();
    logic [SB-1:0] held;
    @(negedge clk);
    held = stateOut;
    msgData = '1;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 hold without valid", stateOut, held);
      check("R6 no done when idle", SB'(stepDone), '0);
    end
  endtask

  task automatic testLoadPriority();
    logic [SB-1:0] v;
    randWide(v);
    @(negedge clk);
    loadEn = 1'b1; loadState = v; msgValid = 1'b1; msgData = 128'hdead_beef;
    #1;
    check("R8 ready low during load", SB'(msgReady), '0);
    @(posedge clk);
    @(negedge clk);
    loadEn = 1'b0; msgValid = 1'b0;
    check("R8 load wins", stateOut, v);
    check("R8 no done on load", SB'(stepDone), '0);
  endtask

  task automatic testSingleSteps();
    logic [SB-1:0] exp;
    logic [SB-1:0] v;
    randWide(v);
    doLoad(v);
    exp = v;
    for (int n = 0; n < 3; n++) begin
      msgData = {4{32'(n) ^ seed}};
      msgValid = 1'b1;
      exp = refStep(exp, msgData);
      @(posedge clk);
      @(negedge clk);
      msgValid = 1'b0;
      check("R3 R4 single step", stateOut, exp);
      @(negedge clk);
      check("R6 hold between steps", stateOut, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      logic [7:0] b;
      for (int y = 1; y < 256; y++) if (mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      b = inv;
      sboxTab[x] = b ^ {b[6:0],b[7]} ^ {b[5:0],b[7:6]} ^ {b[4:0],b[7:5]} ^ {b[3:0],b[7:4]} ^ 8'h63;
    end
    testReset();
    testLoad();
    testZeroStep();
    testBackToBack();
    testIdle();
    testLoadPriority();
    testSingleSteps();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

endmodule